// File: doc/BRIEF.md
# Gated Ternary Second-Order Delta-Sigma Modulator

This block turns one signed fixed-point sample into a stream of ternary pulses (+1, 0, -1) using a discrete second-order delta-sigma loop. A window-start strobe loads the sample and the gain constant n. The loop then runs for part of a window of `WIN` clocks. The feedback magnitude is n·|z|, which is always larger than the input, so the loop stays stable for any normalized input from -1 to +1.

Because the feedback magnitude depends on |z|, the pulse density alone would lose the magnitude. To restore it, the number of cycles the loop runs is made proportional to |z|. A run counter adds a fixed step every active cycle and stops the loop when the count reaches the target set by |z|. Full-scale |z| runs for exactly `WIN` cycles, and a zero sample does not run at all. Outside the run the integrators are held at zero and the output is 0. Averaging the pulses times the gain over the window therefore recovers z.

Top module: `tgdsm_top`

## Requirements
- R1: `pulse_out` is a 2-bit two's-complement ternary code: 2'b01 means +1, 2'b11 means -1 and 2'b00 means 0. During a run it equals the sign of the second integrator, where a value of exactly zero gives 0. The code 2'b10 never appears.
- R2: On a clock edge with `win_start` high, the block captures `z_in` and the gain g = `n_gain`·|`z_in`|. `n_gain` must be at least 2.
- R3: The run starts with both integrators at zero. On each active clock, with y the current output value and fb = y·g: x1 ← sat(x1 + z − fb) and x2 ← sat(x2 + x1 − fb), using the old x1. Saturation is at ±(2^(IW−1)−1), where IW = DW+NW+4.
- R4: After a strobe with nonzero z, `pulse_vld` is high for exactly A = ceil(|z|·WIN / 2^(DW−1)) consecutive cycles, starting in the cycle after the strobe edge. A never exceeds WIN.
- R5: A strobe with `z_in` = 0 produces no active cycle: `pulse_vld` and `pulse_out` stay 0.
- R6: Whenever `pulse_vld` is low, `pulse_out` is 2'b00. When a run ends, the integrators clear, so they cannot carry state into the next run.
- R7: A strobe that arrives during a run abandons that run and starts a new one from zero state with the new sample.
- R8: At full scale (z = 2^(DW−1)−1 and z = −2^(DW−1)), the run lasts WIN cycles. Over any run, |A·z − g·Σy| stays within 16·g, so the loop does not diverge.
- R9: While reset is active and after it is released, the block is idle (`pulse_vld` = 0, `pulse_out` = 0) until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| win_start | input | 1 | Window-start strobe; loads the sample and starts a run |
| z_in | input | DW | Signed input sample |
| n_gain | input | NW | Unsigned gain constant n (at least 2) |
| pulse_out | output | 2 | Signed ternary output code |
| pulse_vld | output | 1 | High while the loop is running |

## Verification
The positive and negative full-scale samples show whether the run lasts the whole window and whether the loop stays bounded at the stability edge. The samples ±1 and −9 show whether the ceiling rounding of the run length is right, giving one or two active cycles. A zero sample shows that a run is suppressed, not merely ended early. A strobe that arrives during a run shows whether integrator state leaks into the next run. Random samples and gains, each checked cycle by cycle against a reference of the difference equations, separate sign or feedback-polarity errors from timing errors.

// File: rtl/tgdsm_pkg.sv
package tgdsm_pkg;
  typedef enum logic [1:0] {
    Q_ZERO = 2'b00,
    Q_POS  = 2'b01,
    Q_NEG  = 2'b11
  } tern_e;
endpackage

// File: rtl/tgdsm_runctl.sv
module tgdsm_runctl #(
  parameter int DW  = 12,
  parameter int WIN = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] mag_in,
  output logic          run,
  output logic          stop
);
  localparam int WB = $clog2(WIN + 1);
  localparam int CW = DW + WB + 1;
  localparam logic [CW-1:0] STEP = CW'(1) << (DW - 1);

  logic          en_q, en_d;
  logic [CW-1:0] cum_q, cum_d, tgt_q, tgt_d, cum_sum;

  always_comb begin
    en_d    = en_q;
    cum_d   = cum_q;
    tgt_d   = tgt_q;
    stop    = 1'b0;
    cum_sum = cum_q + STEP;
    if (start) begin
      en_d  = (mag_in != '0);
      cum_d = '0;
      tgt_d = CW'(mag_in) * CW'(WIN);
    end else if (en_q) begin
      if (cum_sum >= tgt_q) begin
        en_d  = 1'b0;
        cum_d = '0;
        stop  = 1'b1;
      end else begin
        cum_d = cum_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cum_q <= '0;
      tgt_q <= '0;
    end else begin
      en_q  <= en_d;
      cum_q <= cum_d;
      tgt_q <= tgt_d;
    end
  end

  assign run = en_q;
endmodule

// File: rtl/tgdsm_loop.sv
module tgdsm_loop
  import tgdsm_pkg::*;
#(
  parameter int DW = 12,
  parameter int NW = 4,
  parameter int IW = DW + NW + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic                 clr,
  input  logic                 run,
  input  logic signed [DW-1:0] z_in,
  input  logic [DW+NW-1:0]     g_in,
  output tern_e                y_o
);
  localparam int GW = DW + NW;
  localparam int SW = IW + 2;
  localparam logic signed [SW-1:0] HI = {{(SW-IW+1){1'b0}}, {(IW-1){1'b1}}};
  localparam logic signed [SW-1:0] LO = -HI;

  logic signed [DW-1:0] z_q, z_d;
  logic [GW-1:0]        g_q, g_d;
  logic signed [IW-1:0] x1_q, x1_d, x2_q, x2_d;
  logic signed [SW-1:0] fb, s1, s2;
  tern_e                y;

  function automatic logic signed [IW-1:0] sat(input logic signed [SW-1:0] v);
    if (v > HI)      return HI[IW-1:0];
    else if (v < LO) return LO[IW-1:0];
    else             return v[IW-1:0];
  endfunction

  always_comb begin
    if (x2_q > 0)      y = Q_POS;
    else if (x2_q < 0) y = Q_NEG;
    else               y = Q_ZERO;
  end

  always_comb begin
    case (y)
      Q_POS:   fb = $signed({{(SW-GW){1'b0}}, g_q});
      Q_NEG:   fb = -$signed({{(SW-GW){1'b0}}, g_q});
      default: fb = '0;
    endcase
    s1 = SW'(x1_q) + SW'(z_q) - fb;
    s2 = SW'(x2_q) + SW'(x1_q) - fb;
  end

  always_comb begin
    z_d  = z_q;
    g_d  = g_q;
    x1_d = x1_q;
    x2_d = x2_q;
    if (ld) begin
      z_d = z_in;
      g_d = g_in;
    end
    if (clr) begin
      x1_d = '0;
      x2_d = '0;
    end else if (run) begin
      x1_d = sat(s1);
      x2_d = sat(s2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q  <= '0;
      g_q  <= '0;
      x1_q <= '0;
      x2_q <= '0;
    end else begin
      z_q  <= z_d;
      g_q  <= g_d;
      x1_q <= x1_d;
      x2_q <= x2_d;
    end
  end

  assign y_o = y;
endmodule

// File: rtl/tgdsm_top.sv
module tgdsm_top
  import tgdsm_pkg::*;
#(
  parameter int DW  = 12,
  parameter int NW  = 4,
  parameter int WIN = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_start,
  input  logic signed [DW-1:0] z_in,
  input  logic [NW-1:0]        n_gain,
  output logic [1:0]           pulse_out,
  output logic                 pulse_vld
);
  localparam int GW = DW + NW;
  localparam int IW = DW + NW + 4;

  logic [1:0]           rs_q;
  logic                 rst_i;
  logic signed [DW:0]   zx;
  logic [DW-1:0]        mag;
  logic [GW-1:0]        gain;
  logic                 run, stop, clr;
  tern_e                y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign zx   = {z_in[DW-1], z_in};
  assign mag  = z_in[DW-1] ? DW'(-zx) : DW'(zx);
  assign gain = GW'(mag) * GW'(n_gain);
  assign clr  = win_start | stop;

  tgdsm_runctl #(.DW(DW), .WIN(WIN)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_i),
    .start  (win_start),
    .mag_in (mag),
    .run    (run),
    .stop   (stop)
  );

  tgdsm_loop #(.DW(DW), .NW(NW), .IW(IW)) u_loop (
    .clk   (clk),
    .rst_n (rst_i),
    .ld    (win_start),
    .clr   (clr),
    .run   (run),
    .z_in  (z_in),
    .g_in  (gain),
    .y_o   (y)
  );

  assign pulse_vld = run;
  assign pulse_out = run ? y : Q_ZERO;
endmodule

// File: rtl/tgdsm_chk.sv
module tgdsm_chk #(
  parameter int DW  = 12,
  parameter int NW  = 4,
  parameter int WIN = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 win_start,
  input logic signed [DW-1:0] z_in,
  input logic [NW-1:0]        n_gain,
  input logic [1:0]           pulse_out,
  input logic                 pulse_vld
);
  localparam int KW = $clog2(WIN + 2) + 1;
  logic [KW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (win_start) run_cnt <= '0;
    else if (pulse_vld) run_cnt <= run_cnt + 1'b1;
  end

  p_ternary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out != 2'b10);
  p_gain_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |-> n_gain >= NW'(2));
  p_first_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> pulse_out == 2'b00);
  p_start_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start && z_in != '0) |=> pulse_vld);
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= KW'(WIN));
  p_zero_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start && z_in == '0) |=> !pulse_vld);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_vld |-> pulse_out == 2'b00);
endmodule

bind tgdsm_top tgdsm_chk #(.DW(DW), .NW(NW), .WIN(WIN)) u_chk (.*);

// File: tb/tb_tgdsm_top.sv
module tb_tgdsm_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 12;
  localparam int NW  = 4;
  localparam int WIN = 256;
  localparam int IW  = DW + NW + 4;
  localparam longint ZMAX = longint'(1) << (DW - 1);
  localparam longint LIM  = (longint'(1) << (IW - 1)) - 1;

  logic                 clk;
  logic                 rst_n;
  logic                 win_start;
  logic signed [DW-1:0] z_in;
  logic [NW-1:0]        n_gain;
  logic [1:0]           pulse_out;
  logic                 pulse_vld;

  int n_chk = 0;
  int n_bad = 0;

  tgdsm_top #(.DW(DW), .NW(NW), .WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .z_in(z_in),
    .n_gain(n_gain), .pulse_out(pulse_out), .pulse_vld(pulse_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint f_sat(input longint v);
    if (v > LIM)  return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  function automatic longint f_sign(input longint v);
    if (v > 0) return 1;
    if (v < 0) return -1;
    return 0;
  endfunction

  function automatic longint f_active(input longint mag);
    return (mag * WIN + ZMAX - 1) / ZMAX;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_win(input int z, input int n, input int len);
    longint x1 = 0, x2 = 0, g, mag, ys, fb, nx1, nx2, errsum = 0, ysum = 0;
    longint k = 0, act = 0, exp_a;
    bit ren;
    mag   = (z < 0) ? -z : z;
    g     = n * mag;
    exp_a = f_active(mag);
    ren   = (mag != 0);
    @(negedge clk);
    win_start = 1'b1;
    z_in      = z[DW-1:0];
    n_gain    = n[NW-1:0];
    @(negedge clk);
    win_start = 1'b0;
    for (int c = 0; c < len; c++) begin
      ys = ren ? f_sign(x2) : 0;
      chk("R1/R3 pulse_out", longint'($signed(pulse_out)), ys);
      chk("R6 pulse_vld", longint'(pulse_vld), longint'(ren));
      if (pulse_vld) act++;
      if (ren) begin
        fb  = ys * g;
        nx1 = f_sat(x1 + z - fb);
        nx2 = f_sat(x2 + x1 - fb);
        errsum += z - fb;
        ysum   += ys;
        x1 = nx1;
        x2 = nx2;
        k++;
        if (k * ZMAX >= mag * WIN) begin
          ren = 1'b0;
          x1  = 0;
          x2  = 0;
        end
      end
      @(negedge clk);
    end
    if (len > exp_a) begin
      if (mag == 0) chk("R5 run length", act, 0);
      else          chk("R4 run length", act, exp_a);
      n_chk++;
      if (errsum > 16 * g || errsum < -16 * g) begin
        n_bad++;
        $display("FAIL R8 loop error: got %0d expected within %0d (sum y %0d)",
                 errsum, 16 * g, ysum);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    win_start = 1'b0;
    z_in      = '0;
    n_gain    = 4'd2;
    repeat (3) @(negedge clk);
    chk("R9 vld in reset", longint'(pulse_vld), 0);
    chk("R9 out in reset", longint'(pulse_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 vld after reset", longint'(pulse_vld), 0);
    chk("R9 out after reset", longint'(pulse_out), 0);

    run_win(0, 3, 20);                 // R5 zero sample
    run_win(2047, 2, WIN + 4);         // R8 positive full scale
    run_win(-2048, 15, WIN + 4);       // R8 negative full scale
    run_win(1, 4, 10);                 // R4 single active cycle
    run_win(-1, 7, 10);                // R4 single active cycle, negative
    run_win(-9, 5, 10);                // R4 rounding up to two cycles
    run_win(1024, 3, 40);              // R7 cut short by next strobe
    run_win(-500, 6, WIN + 2);         // R7 fresh run after restart
    run_win(300, 2, 12);               // R7 another cut-short run
    run_win(0, 9, 12);                 // R5 zero cuts a run and stays idle
    for (int i = 0; i < 24; i++) begin
      int zr, nr;
      zr = int'($urandom_range(4095, 0)) - 2048;
      nr = int'($urandom_range(15, 2));
      run_win(zr, nr, WIN + 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule